// File: doc/BRIEF.md
# Fuse shadow register bank

This block keeps a register copy ("shadow") of every word of a one-time-programmable fuse array and makes the copies readable through a memory-mapped window on a single-cycle register port. Software sees each shadow word at its own 16-byte slot in the window. Beside the window sit a control register, set and clear aliases of it, and a timing register. A reload request copies the whole fuse array into the shadows, one word per clock after a programmable settling delay. The control register reports busy for the whole reload.

Each word can carry a read lock and a write lock, both fixed by parameter vectors. A forbidden access does not reach the shadow. Instead it raises one shared sticky error flag. Any window access, and any further reload request, made while a reload is running also raises the flag. While the flag is set the bank refuses all new window reads, window writes and reload requests. Software has to clear the flag through the clear alias before it can continue.

Every request is accepted in the cycle it is presented. Read data returns on the next clock with a valid strobe. The reset input is asserted asynchronously and released synchronously to the clock. The fuse cells are modelled inside the block as a computed constant array.

Top module: `fsb_shadow_bank`

## Requirements
- R1: After reset, the control register (0x000) reads 0, the timing register (0x010) reads the reset delay (default 2) in bits [15:12], and every shadow word reads 0.
- R2: Shadow word n answers at byte offset 0x400 + n*0x10. A read drives rsp_valid high with the data on the clock after the request, and rsp_valid is low after writes and idle cycles.
- R3: While the bank is idle and error-free, a write to a shadow word that is not write-locked stores the 32-bit data, and a later read returns it.
- R4: Writing 1 to bit 10 of the set alias (0x004) starts a reload. Control bits 8 (busy) and 10 (reload) read 1 for exactly DELAY + N_WORDS cycles and then both read 0. After that, word n holds (n*0x9E3779B1) XOR 0x5A0FC3E1, and this overwrites any value written earlier.
- R5: Reading a read-locked word (default words 5 and 127) returns 0xBADABADA and sets the error flag, which reads as control bit 9.
- R6: Writing a write-locked word (default words 0, 1 and 5) sets the error flag and leaves the word unchanged.
- R7: A window read or write made during a reload sets the error flag. The read returns 0xBADABADA and the write is discarded. A reload request made during a reload also sets the error flag and does not extend the reload.
- R8: While the error flag is set, window reads return 0xBADABADA, window writes are discarded, and reload requests are ignored. The flag stays set.
- R9: The error flag clears only when bit 9 is written as 1 to the clear alias (0x008). A clear write without bit 9 leaves the flag set.
- R10: Window offsets that are not on a 0x10 boundary, and offsets past the last word, read as 0 and never set the error flag. Writes to them change no shadow word.
- R11: The timing register keeps only the delay field in bits [15:12], and all its other bits read 0. The delay is captured when a reload starts, so a change written during a reload does not alter that reload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low reset, asserted asynchronously, released synchronously |
| req_valid_i | input | 1 | A request is present this cycle |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 12 | Byte address of the request |
| req_wdata_i | input | 32 | Write data |
| rsp_valid_o | output | 1 | Read data is valid this cycle (one clock after the read) |
| rsp_rdata_o | output | 32 | Read data, 0 when no read is answered |

## Verification
A wrong sequencer count shows up at the ports in two ways. The busy bit falls one cycle early or late, which a control poll sees in that very cycle. Or a word holds the wrong value, which the first read after the reload shows. A stuck or lost error flag shows on the next window read: the data switches between the sentinel and the shadow contents, and the control register's bit 9 shows the same fault on the next poll. A lock check or window decode that selects the wrong word shows on the next read of that word or of its neighbour. The reference model therefore compares every response on every clock, so each fault is seen within one cycle of the request that exposes it.

// File: rtl/fsb_pkg.sv
package fsb_pkg;

  localparam int unsigned DATA_W     = 32;
  localparam logic [31:0] SENTINEL   = 32'hBADA_BADA;

  // control register bit positions
  localparam int unsigned BIT_BUSY   = 8;
  localparam int unsigned BIT_ERR    = 9;
  localparam int unsigned BIT_RELOAD = 10;

  // timing register: delay field position
  localparam int unsigned DELAY_LSB  = 12;

  // register offsets and the shadow window geometry
  localparam int unsigned OFS_CTRL   = 32'h000;
  localparam int unsigned OFS_SET    = 32'h004;
  localparam int unsigned OFS_CLR    = 32'h008;
  localparam int unsigned OFS_TIMING = 32'h010;
  localparam int unsigned WIN_BASE   = 32'h400;
  localparam int unsigned WIN_STRIDE = 16;

  typedef enum logic [2:0] {
    K_NONE,
    K_CTRL,
    K_SET,
    K_CLR,
    K_TIMING,
    K_WORD
  } fsb_kind_e;

  // content of the modelled fuse cell array
  function automatic logic [31:0] fuse_word(input int unsigned idx, input logic [31:0] seed);
    logic [31:0] prod;
    prod = idx * 32'h9E37_79B1;
    return prod ^ seed;
  endfunction

endpackage

// File: rtl/fsb_decode.sv
module fsb_decode
  import fsb_pkg::*;
#(
  parameter  int unsigned N_WORDS = 128,
  parameter  int unsigned ADDR_W  = 12,
  localparam int unsigned IDX_W   = $clog2(N_WORDS)
) (
  input  logic [ADDR_W-1:0] addr_i,
  output fsb_kind_e         kind_o,
  output logic [IDX_W-1:0]  idx_o
);

  localparam int unsigned SLOT_LSB = $clog2(WIN_STRIDE);
  localparam int unsigned SLOT_W   = ADDR_W - SLOT_LSB;

  logic [ADDR_W-1:0] off;
  logic [SLOT_W-1:0] slot;
  logic              in_win;
  logic              aligned;
  logic              in_range;

  assign off      = addr_i - ADDR_W'(WIN_BASE);
  assign slot     = off[ADDR_W-1:SLOT_LSB];
  assign in_win   = (addr_i >= ADDR_W'(WIN_BASE));
  assign aligned  = (off[SLOT_LSB-1:0] == '0);
  assign in_range = (32'(slot) < N_WORDS);
  assign idx_o    = slot[IDX_W-1:0];

  always_comb begin
    kind_o = K_NONE;
    if (addr_i == ADDR_W'(OFS_CTRL)) begin
      kind_o = K_CTRL;
    end else if (addr_i == ADDR_W'(OFS_SET)) begin
      kind_o = K_SET;
    end else if (addr_i == ADDR_W'(OFS_CLR)) begin
      kind_o = K_CLR;
    end else if (addr_i == ADDR_W'(OFS_TIMING)) begin
      kind_o = K_TIMING;
    end else if (in_win && aligned && in_range) begin
      kind_o = K_WORD;
    end
  end

endmodule

// File: rtl/fsb_fuse_array.sv
module fsb_fuse_array
  import fsb_pkg::*;
#(
  parameter  int unsigned N_WORDS = 128,
  parameter  logic [31:0] SEED    = 32'h5A0F_C3E1,
  localparam int unsigned IDX_W   = $clog2(N_WORDS)
) (
  input  logic [IDX_W-1:0]  idx_i,
  output logic [DATA_W-1:0] word_o
);

  logic [DATA_W-1:0] cells [N_WORDS];

  for (genvar g = 0; g < N_WORDS; g++) begin : g_cell
    assign cells[g] = fuse_word(g, SEED);
  end

  assign word_o = cells[idx_i];

endmodule

// File: rtl/fsb_reload_seq.sv
module fsb_reload_seq #(
  parameter  int unsigned N_WORDS = 128,
  parameter  int unsigned DELAY_W = 4,
  localparam int unsigned IDX_W   = $clog2(N_WORDS)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic [DELAY_W-1:0] delay_i,
  output logic               busy_o,
  output logic               copy_en_o,
  output logic [IDX_W-1:0]   copy_idx_o
);

  localparam logic [IDX_W-1:0] LAST = IDX_W'(N_WORDS - 1);

  logic               run_q,  run_d;
  logic [DELAY_W-1:0] wait_q, wait_d;
  logic [IDX_W-1:0]   idx_q,  idx_d;
  logic               copy_en;

  // next state: settle for the captured delay, then one word per clock
  always_comb begin
    run_d   = run_q;
    wait_d  = wait_q;
    idx_d   = idx_q;
    copy_en = 1'b0;
    if (!run_q) begin
      if (start_i) begin
        run_d  = 1'b1;
        wait_d = delay_i;
        idx_d  = '0;
      end
    end else if (wait_q != '0) begin
      wait_d = wait_q - 1'b1;
    end else begin
      copy_en = 1'b1;
      if (idx_q == LAST) begin
        run_d = 1'b0;
      end else begin
        idx_d = idx_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q  <= 1'b0;
      wait_q <= '0;
      idx_q  <= '0;
    end else begin
      run_q  <= run_d;
      wait_q <= wait_d;
      idx_q  <= idx_d;
    end
  end

  assign busy_o     = run_q;
  assign copy_en_o  = copy_en;
  assign copy_idx_o = idx_q;

  AST_START_RAISES_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |=> busy_o); // R4
  AST_ENDS_ON_LAST_WORD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> ($past(copy_en_o) && ($past(copy_idx_o) == LAST))); // R4

endmodule

// File: rtl/fsb_shadow_bank.sv
module fsb_shadow_bank
  import fsb_pkg::*;
#(
  parameter int unsigned          N_WORDS   = 128,
  parameter int unsigned          ADDR_W    = 12,
  parameter int unsigned          DELAY_W   = 4,
  parameter logic [DELAY_W-1:0]   DELAY_RST = DELAY_W'(2),
  parameter logic [31:0]          FUSE_SEED = 32'h5A0F_C3E1,
  parameter logic [N_WORDS-1:0]   RD_LOCK   = (N_WORDS'(1) << (N_WORDS - 1)) | N_WORDS'(32'h20),
  parameter logic [N_WORDS-1:0]   WR_LOCK   = N_WORDS'(32'h23)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic              req_write_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [31:0]       req_wdata_i,
  output logic              rsp_valid_o,
  output logic [31:0]       rsp_rdata_o
);

  localparam int unsigned IDX_W = $clog2(N_WORDS);

  fsb_kind_e          kind;
  logic [IDX_W-1:0]   widx;
  logic               busy;
  logic               copy_en;
  logic [IDX_W-1:0]   copy_idx;
  logic [31:0]        fuse_q;

  logic [DELAY_W-1:0] delay_q, delay_d;
  logic               error_q, error_d;
  logic               rsp_valid_q, rsp_valid_d;
  logic [31:0]        rsp_rdata_q, rsp_rdata_d;
  logic [31:0]        shadow_q [N_WORDS];

  logic               rd_req, wr_req, word_rd, word_wr;
  logic               rd_lock, wr_lock;
  logic               reload_req, start, err_set, err_clr;
  logic               sh_we;
  logic [IDX_W-1:0]   sh_idx;
  logic [31:0]        sh_data;

  fsb_decode #(.N_WORDS(N_WORDS), .ADDR_W(ADDR_W)) u_decode (
    .addr_i (req_addr_i),
    .kind_o (kind),
    .idx_o  (widx)
  );

  fsb_reload_seq #(.N_WORDS(N_WORDS), .DELAY_W(DELAY_W)) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start),
    .delay_i    (delay_q),
    .busy_o     (busy),
    .copy_en_o  (copy_en),
    .copy_idx_o (copy_idx)
  );

  fsb_fuse_array #(.N_WORDS(N_WORDS), .SEED(FUSE_SEED)) u_fuse (
    .idx_i  (copy_idx),
    .word_o (fuse_q)
  );

  // request classification and lock lookup
  assign rd_req     = req_valid_i && !req_write_i;
  assign wr_req     = req_valid_i &&  req_write_i;
  assign word_rd    = rd_req && (kind == K_WORD);
  assign word_wr    = wr_req && (kind == K_WORD);
  assign rd_lock    = RD_LOCK[widx];
  assign wr_lock    = WR_LOCK[widx];
  assign reload_req = wr_req && (kind == K_SET) && req_wdata_i[BIT_RELOAD];
  assign start      = reload_req && !busy && !error_q;

  // error flag: violations set, clear alias bit 9 clears
  always_comb begin
    err_set = 1'b0;
    if ((word_rd || word_wr) && busy) begin
      err_set = 1'b1;
    end else if (word_rd && !error_q && rd_lock) begin
      err_set = 1'b1;
    end else if (word_wr && !error_q && wr_lock) begin
      err_set = 1'b1;
    end else if (reload_req && busy) begin
      err_set = 1'b1;
    end
    err_clr = wr_req && (kind == K_CLR) && req_wdata_i[BIT_ERR];
    error_d = error_q;
    if (err_set) begin
      error_d = 1'b1;
    end else if (err_clr) begin
      error_d = 1'b0;
    end
  end

  // timing register holds only the delay field
  always_comb begin
    delay_d = delay_q;
    if (wr_req && (kind == K_TIMING)) begin
      delay_d = req_wdata_i[DELAY_LSB +: DELAY_W];
    end
  end

  // shadow write port: reload copy or accepted bus write (never both)
  always_comb begin
    sh_we   = 1'b0;
    sh_idx  = widx;
    sh_data = req_wdata_i;
    if (copy_en) begin
      sh_we   = 1'b1;
      sh_idx  = copy_idx;
      sh_data = fuse_q;
    end else if (word_wr && !busy && !error_q && !wr_lock) begin
      sh_we = 1'b1;
    end
  end

  // read response
  always_comb begin
    rsp_valid_d = rd_req;
    rsp_rdata_d = '0;
    if (rd_req) begin
      unique case (kind)
        K_CTRL: begin
          rsp_rdata_d[BIT_BUSY]   = busy;
          rsp_rdata_d[BIT_ERR]    = error_q;
          rsp_rdata_d[BIT_RELOAD] = busy;
        end
        K_TIMING: rsp_rdata_d[DELAY_LSB +: DELAY_W] = delay_q;
        K_WORD:   rsp_rdata_d = (busy || error_q || rd_lock) ? SENTINEL : shadow_q[widx];
        default:  rsp_rdata_d = '0;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      delay_q     <= DELAY_RST;
      error_q     <= 1'b0;
      rsp_valid_q <= 1'b0;
      rsp_rdata_q <= '0;
    end else begin
      delay_q     <= delay_d;
      error_q     <= error_d;
      rsp_valid_q <= rsp_valid_d;
      rsp_rdata_q <= rsp_rdata_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < N_WORDS; i++) begin
        shadow_q[i] <= '0;
      end
    end else if (sh_we) begin
      shadow_q[sh_idx] <= sh_data;
    end
  end

  assign rsp_valid_o = rsp_valid_q;
  assign rsp_rdata_o = rsp_rdata_q;

  AST_LOCKED_READ_SENTINEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (word_rd && rd_lock) |=> (rsp_rdata_o == SENTINEL)); // R5
  AST_LOCKED_READ_FLAGS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (word_rd && rd_lock) |=> error_q); // R5
  AST_LOCKED_WRITE_FLAGS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (word_wr && wr_lock) |=> error_q); // R6
  AST_BUSY_ACCESS_FLAGS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((word_rd || word_wr) && busy) |=> error_q); // R7
  AST_NO_START_WHILE_ERR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (error_q && !busy) |=> !busy); // R8
  AST_ERR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (error_q && !err_clr) |=> error_q); // R9
  AST_HOLE_READS_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_req && (kind == K_NONE)) |=> (rsp_rdata_o == '0)); // R10
  AST_READ_ANSWERED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req |=> rsp_valid_o); // R2

endmodule

// File: tb/fsb_shadow_bank_tb.sv
module fsb_shadow_bank_tb;

  localparam int          CLK_PERIOD = 10;
  localparam int          N          = 128;
  localparam logic [31:0] SEED       = 32'h5A0F_C3E1;
  localparam logic [31:0] SENT       = 32'hBADA_BADA;
  localparam logic [11:0] A_CTRL     = 12'h000;
  localparam logic [11:0] A_SET      = 12'h004;
  localparam logic [11:0] A_CLR      = 12'h008;
  localparam logic [11:0] A_TIM      = 12'h010;

  logic        clk;
  logic        rst_n;
  logic        req_valid;
  logic        req_write;
  logic [11:0] req_addr;
  logic [31:0] req_wdata;
  logic        rsp_valid;
  logic [31:0] rsp_rdata;

  int unsigned n_vec;
  int unsigned n_bad;
  bit          done;

  // reference model state
  logic [31:0] m_sh [N];
  bit          m_err;
  int          m_rem;
  int          m_delay;
  logic        m_exp_valid;
  logic [31:0] m_exp_data;
  string       m_exp_tag;

  fsb_shadow_bank u_dut (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .req_valid_i (req_valid),
    .req_write_i (req_write),
    .req_addr_i  (req_addr),
    .req_wdata_i (req_wdata),
    .rsp_valid_o (rsp_valid),
    .rsp_rdata_o (rsp_rdata)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  function automatic logic [31:0] fuse_ref(input int i);
    logic [31:0] i32;
    i32 = i;
    return (i32 * 32'h9E37_79B1) ^ SEED;
  endfunction

  function automatic bit rd_locked(input int i);
    return (i == 5) || (i == 127);
  endfunction

  function automatic bit wr_locked(input int i);
    return (i == 0) || (i == 1) || (i == 5);
  endfunction

  function automatic logic [11:0] wa(input int i);
    return 12'(32'h400 + i * 16);
  endfunction

  task automatic compare();
    n_vec++;
    if (rsp_valid !== m_exp_valid || rsp_rdata !== m_exp_data) begin
      n_bad++;
      $display("FAIL %s: actual valid=%0b data=%h expected valid=%0b data=%h",
               m_exp_tag, rsp_valid, rsp_rdata, m_exp_valid, m_exp_data);
    end
  endtask

  // behavioural model of one clock edge with the given request
  task automatic model(input bit v, input bit w, input logic [11:0] a,
                       input logic [31:0] d, input string tag);
    bit busy;
    bit start;
    int idx;
    int off;
    busy  = (m_rem > 0);
    start = 1'b0;
    idx   = -1;
    off   = int'(a) - 1024;
    if (off >= 0 && (off % 16) == 0 && (off / 16) < N) idx = off / 16;
    m_exp_valid = v && !w;
    m_exp_data  = '0;
    m_exp_tag   = tag;
    if (v && !w) begin
      if (a == A_CTRL) begin
        m_exp_data = (32'(busy) << 10) | (32'(m_err) << 9) | (32'(busy) << 8);
      end else if (a == A_TIM) begin
        m_exp_data = 32'(m_delay) << 12;
      end else if (idx >= 0) begin
        if (busy) begin
          m_exp_data = SENT; m_err = 1'b1;
        end else if (m_err) begin
          m_exp_data = SENT;
        end else if (rd_locked(idx)) begin
          m_exp_data = SENT; m_err = 1'b1;
        end else begin
          m_exp_data = m_sh[idx];
        end
      end
    end else if (v && w) begin
      if (a == A_SET) begin
        if (d[10]) begin
          if (busy) m_err = 1'b1;
          else if (!m_err) start = 1'b1;
        end
      end else if (a == A_CLR) begin
        if (d[9]) m_err = 1'b0;
      end else if (a == A_TIM) begin
        m_delay = int'(d[15:12]);
      end else if (idx >= 0) begin
        if (busy) m_err = 1'b1;
        else if (m_err) ;
        else if (wr_locked(idx)) m_err = 1'b1;
        else m_sh[idx] = d;
      end
    end
    if (m_rem > 0) begin
      m_rem--;
      if (m_rem == 0) begin
        for (int i = 0; i < N; i++) m_sh[i] = fuse_ref(i);
      end
    end
    if (start) m_rem = m_delay + N;
  endtask

  task automatic step(input bit v, input bit w, input logic [11:0] a,
                      input logic [31:0] d, input string tag);
    @(negedge clk);
    compare();
    model(v, w, a, d, tag);
    req_valid = v;
    req_write = w;
    req_addr  = a;
    req_wdata = d;
  endtask

  task automatic rd(input logic [11:0] a, input string tag);
    step(1'b1, 1'b0, a, 32'h0, tag);
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d, input string tag);
    step(1'b1, 1'b1, a, d, tag);
  endtask

  task automatic idle(input string tag);
    step(1'b0, 1'b0, 12'h0, 32'h0, tag);
  endtask

  task automatic poll_reload(input string tag);
    while (m_rem > 0) rd(A_CTRL, tag);
    rd(A_CTRL, tag);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_bad++;
      $display("FAIL R4 watchdog: actual no completion expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    n_vec = 0; n_bad = 0; done = 1'b0;
    req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_wdata = '0;
    for (int i = 0; i < N; i++) m_sh[i] = '0;
    m_err = 1'b0; m_rem = 0; m_delay = 2;
    m_exp_valid = 1'b0; m_exp_data = '0; m_exp_tag = "R1";
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    rd(A_CTRL, "R1");
    rd(A_TIM, "R1");
    rd(wa(0), "R1");
    rd(wa(10), "R1");
    rd(wa(126), "R1");

    // R3 / R2: store and read back through the window mapping
    wr(wa(10), 32'h1234_5678, "R3");
    idle("R2");
    rd(wa(10), "R2");
    wr(wa(64), 32'hCAFE_F00D, "R3");
    rd(wa(64), "R3");
    rd(wa(11), "R2");

    // R10: holes and out-of-range offsets
    rd(12'h4A4, "R10");
    rd(12'h4A8, "R10");
    rd(12'h40C, "R10");
    rd(12'hC00, "R10");
    rd(12'hFF0, "R10");
    wr(12'h4A4, 32'hFFFF_FFFF, "R10");
    wr(12'hC00, 32'hFFFF_FFFF, "R10");
    rd(wa(10), "R10");
    rd(A_CTRL, "R10");

    // R11: delay field only
    wr(A_TIM, 32'hFFFF_3FFF, "R11");
    rd(A_TIM, "R11");

    // R4 + R11: reload with delay 3, delay changed mid-reload
    wr(A_SET, 32'h0000_0400, "R4");
    rd(A_CTRL, "R4");
    wr(A_TIM, 32'h0000_F000, "R11");
    poll_reload("R4");
    rd(A_TIM, "R11");
    for (int i = 0; i < N; i++) begin
      if (!rd_locked(i)) rd(wa(i), "R4");
    end
    rd(A_CTRL, "R4");

    // R5: read-locked word
    rd(wa(5), "R5");
    rd(A_CTRL, "R5");
    // R8: refused while error set
    rd(wa(10), "R8");
    wr(wa(10), 32'h0BAD_0BAD, "R8");
    wr(A_SET, 32'h0000_0400, "R8");
    rd(A_CTRL, "R8");
    // R9: clear only through bit 9
    wr(A_CLR, 32'h0000_0500 & 32'hFFFF_FDFF, "R9");
    rd(A_CTRL, "R9");
    wr(A_CLR, 32'h0000_0200, "R9");
    rd(A_CTRL, "R9");
    rd(wa(10), "R8");
    rd(wa(127), "R5");
    wr(A_CLR, 32'h0000_0200, "R9");

    // R6: write-locked word
    wr(wa(1), 32'h5555_AAAA, "R6");
    rd(A_CTRL, "R6");
    wr(A_CLR, 32'h0000_0200, "R9");
    rd(wa(1), "R6");
    wr(wa(0), 32'h1111_1111, "R6");
    wr(A_CLR, 32'h0000_0200, "R9");
    rd(wa(0), "R6");

    // R7: accesses during a reload (delay now 0)
    wr(A_TIM, 32'h0000_0000, "R11");
    wr(wa(20), 32'h7777_7777, "R3");
    wr(A_SET, 32'h0000_0400, "R4");
    idle("R7");
    rd(wa(20), "R7");
    wr(wa(20), 32'h8888_8888, "R7");
    wr(A_SET, 32'h0000_0400, "R7");
    poll_reload("R7");
    wr(A_CLR, 32'h0000_0200, "R9");
    rd(wa(20), "R7");
    rd(A_CTRL, "R7");

    // R4: reload length with delay 0 from a clean state
    wr(wa(30), 32'h0, "R3");
    rd(wa(30), "R3");
    wr(A_SET, 32'h0000_0400, "R4");
    poll_reload("R4");
    rd(wa(30), "R4");
    rd(wa(N - 2), "R4");
    idle("R2");
    idle("R2");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule